// File: doc/BRIEF.md
# Lockable Write-Protection Controller

This block holds one 16-bit control register with two independent 2-bit protection fields. Each field guards a separate group of configuration registers. One group holds the clock-enable and power-down controls. The other holds the pin-function selection and pad controls. Each field is decoded into a protect level and a lock flag. Writes from a simple synchronous register bus that fall inside a protected group's address window are dropped without a bus error. The block does this by holding back that group's gated write enable.

A field whose lock bit is set can no longer be changed by software. It keeps its protect setting until the next reset, so a chosen protection state can be frozen for the rest of the session. The two fields lock independently of each other. The protected registers themselves live outside this block. The bench drives a stub register group from the gated write enables.

Top module: `wprot_ctrl`

## Requirements
- R1: After a synchronous reset both fields are 00, so all protect and lock outputs are low and a read of the protection register returns 0.
- R2: Bits 3:2 of the protection register hold the clock-group field and bits 1:0 hold the pin-group field; bits 15:4 always read 0 and values written there are discarded.
- R3: In each field bit 0 is the protect bit and bit 1 is the lock bit: 00 means off, 01 means on, 10 means off and locked, 11 means on and locked. The protect and lock outputs show the field bits.
- R4: An unlocked field takes whatever value is written to it, so it can go from 00 to 01 and back, or into 10 or 11.
- R5: Once a field's lock bit is set, writes to that field have no effect until reset.
- R6: In a write that covers both fields, a locked field keeps its value while the unlocked field still updates.
- R7: `clk_grp_we` is high only when `bus_we` is high, `bus_addr` lies in [CLK_BASE, CLK_BASE+CLK_COUNT), and the clock-group protect bit is low.
- R8: `pin_grp_we` is high only when `bus_we` is high, `bus_addr` lies in [PIN_BASE, PIN_BASE+PIN_COUNT), and the pin-group protect bit is low.
- R9: A write to an address that is neither the protection register nor in either window changes no field and raises no group write enable.
- R10: Reset clears a locked field back to 00.
- R11: `bus_rdata` is registered. One cycle after an address is presented it shows the protection register (default address 0x12) if the address matched, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | DATA_W | Register bus write data |
| bus_rdata | output | DATA_W | Registered read data |
| clk_grp_we | output | 1 | Gated write enable for the clock-group window |
| pin_grp_we | output | 1 | Gated write enable for the pin-group window |
| clk_protect | output | 1 | Clock-group protect level |
| clk_locked | output | 1 | Clock-group lock flag |
| pin_protect | output | 1 | Pin-group protect level |
| pin_locked | output | 1 | Pin-group lock flag |

## Verification
The bench targets the following corner cases:

- **Field writes against lock state.** A single write that moves an unlocked field while its neighbour is locked would, in a design that applies the lock to the whole register, freeze both fields. A design that ignores the lock would let the locked field change.
- **Reserved bits.** Writes with every reserved bit set would show up as nonzero upper read bits if those bits were stored.
- **Group window boundaries.** Writes to the first and last address of each group window, and to an address just outside, would expose an off-by-one window decode or swapped protect bits between the groups.
- **Reset after locking.** A reset after a lock must return the register to 00. A lock that survived reset would keep a group protected.

// File: rtl/wp_pkg.sv
package wp_pkg;
  // one protection field: lock is the upper bit, protect the lower
  typedef struct packed {
    logic lock;
    logic prot;
  } wp_field_t;
  localparam int FIELD_W = 2;
endpackage

// File: rtl/wp_field.sv
module wp_field
  import wp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  wp_field_t wr_val,
  output wp_field_t q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (wr_en && !q.lock)
      q <= wr_val;
  end
endmodule

// File: rtl/wp_window_gate.sv
module wp_window_gate #(
  parameter int ADDR_W = 8,
  parameter int BASE   = 32,
  parameter int COUNT  = 4
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              protect,
  output logic              gated_we
);
  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE + COUNT);
  logic [ADDR_W:0] a_ext;
  logic            hit;
  assign a_ext    = {1'b0, bus_addr};
  assign hit      = (a_ext >= LO) && (a_ext < HI);
  assign gated_we = bus_we && hit && !protect;
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int PROT_ADDR = 18,
  parameter int CLK_BASE  = 32,
  parameter int CLK_COUNT = 4,
  parameter int PIN_BASE  = 64,
  parameter int PIN_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              clk_grp_we,
  output logic              pin_grp_we,
  output logic              clk_protect,
  output logic              clk_locked,
  output logic              pin_protect,
  output logic              pin_locked
);
  // field 0 = pin group (bits 1:0), field 1 = clock group (bits 3:2)
  localparam int NFIELD = 2;
  localparam int FLAT_W = NFIELD * FIELD_W;
  localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(PROT_ADDR);

  logic              reg_wr;
  logic [FLAT_W-1:0] flat;
  wp_field_t         fq [NFIELD];
  logic [DATA_W-1:0] rdata_q;

  assign reg_wr = bus_we && (bus_addr == REG_A);

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    wp_field u_field (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (reg_wr),
      .wr_val (wp_field_t'(bus_wdata[g*FIELD_W +: FIELD_W])),
      .q      (fq[g])
    );
    assign flat[g*FIELD_W +: FIELD_W] = fq[g];
  end

  assign pin_protect = fq[0].prot;
  assign pin_locked  = fq[0].lock;
  assign clk_protect = fq[1].prot;
  assign clk_locked  = fq[1].lock;

  wp_window_gate #(.ADDR_W(ADDR_W), .BASE(CLK_BASE), .COUNT(CLK_COUNT)) u_clk_gate (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .protect  (fq[1].prot),
    .gated_we (clk_grp_we)
  );

  wp_window_gate #(.ADDR_W(ADDR_W), .BASE(PIN_BASE), .COUNT(PIN_COUNT)) u_pin_gate (
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .protect  (fq[0].prot),
    .gated_we (pin_grp_we)
  );

  // registered read: reserved bits come back as zero
  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (bus_addr == REG_A)
      rdata_q <= {{(DATA_W-FLAT_W){1'b0}}, flat};
    else
      rdata_q <= '0;
  end
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              clk_grp_we,
  input logic              pin_grp_we,
  input logic              clk_protect,
  input logic              clk_locked,
  input logic              pin_protect,
  input logic              pin_locked
);
  assert_clk_lock_hold_R5: assert property (@(posedge clk) disable iff (rst)
    clk_locked |=> (clk_locked && $stable(clk_protect)));
  assert_pin_lock_hold_R5: assert property (@(posedge clk) disable iff (rst)
    pin_locked |=> (pin_locked && $stable(pin_protect)));
  assert_clk_gate_R7: assert property (@(posedge clk) disable iff (rst)
    clk_protect |-> !clk_grp_we);
  assert_pin_gate_R8: assert property (@(posedge clk) disable iff (rst)
    pin_protect |-> !pin_grp_we);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:4] == '0);
  assert_windows_apart_R9: assert property (@(posedge clk) disable iff (rst)
    !(clk_grp_we && pin_grp_we));
endmodule

bind wprot_ctrl wprot_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_rdata   (bus_rdata),
  .clk_grp_we  (clk_grp_we),
  .pin_grp_we  (pin_grp_we),
  .clk_protect (clk_protect),
  .clk_locked  (clk_locked),
  .pin_protect (pin_protect),
  .pin_locked  (pin_locked)
);

// File: tb/wprot_ctrl_test.sv
`timescale 1ns/1ps
module wprot_ctrl_test;
  localparam int PROT = 18, CB = 32, CN = 4, PB = 64, PN = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic clk_grp_we, pin_grp_we, clk_protect, clk_locked, pin_protect, pin_locked;

  int errors = 0, checks = 0;
  int m_clk = 0, m_pin = 0;
  bit done = 0;
  logic [15:0] stub_c [CN];
  logic [15:0] stub_p [PN];
  logic [15:0] mod_c [CN];
  logic [15:0] mod_p [PN];

  always #2.5 clk = ~clk;

  wprot_ctrl uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_grp_we(clk_grp_we), .pin_grp_we(pin_grp_we),
    .clk_protect(clk_protect), .clk_locked(clk_locked),
    .pin_protect(pin_protect), .pin_locked(pin_locked)
  );

  // stub protected group written through the gated enables
  always_ff @(posedge clk) begin
    if (clk_grp_we) stub_c[bus_addr - 8'(CB)] <= bus_wdata;
    if (pin_grp_we) stub_p[bus_addr - 8'(PB)] <= bus_wdata;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_state();
    check("R3 clk_protect", int'(clk_protect), m_clk & 1);
    check("R3/R5 clk_locked", int'(clk_locked), (m_clk >> 1) & 1);
    check("R3 pin_protect", int'(pin_protect), m_pin & 1);
    check("R3/R5 pin_locked", int'(pin_locked), (m_pin >> 1) & 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_we = 1'b0; bus_addr = '0;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    m_clk = 0; m_pin = 0;
    check_state();
    check("R1 rdata", int'(bus_rdata), 0);
  endtask

  task automatic step(input int a, input bit w, input int d);
    int ecw, epw, erd;
    @(negedge clk);
    bus_addr = 8'(a); bus_we = w; bus_wdata = 16'(d);
    #1;
    ecw = (w && a >= CB && a < CB + CN && (m_clk & 1) == 0) ? 1 : 0;
    epw = (w && a >= PB && a < PB + PN && (m_pin & 1) == 0) ? 1 : 0;
    check("R7 clk_grp_we", int'(clk_grp_we), ecw);
    check("R8 pin_grp_we", int'(pin_grp_we), epw);
    erd = (a == PROT) ? ((m_clk << 2) | m_pin) : 0;
    if (w && a == PROT) begin
      if ((m_clk & 2) == 0) m_clk = (d >> 2) & 3;
      if ((m_pin & 2) == 0) m_pin = d & 3;
    end
    if (ecw == 1) mod_c[a - CB] = 16'(d);
    if (epw == 1) mod_p[a - PB] = 16'(d);
    @(posedge clk);
    #1;
    check("R2/R11 rdata", int'(bus_rdata), erd);
    check_state();
    bus_we = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < CN; i++) begin stub_c[i] = '0; mod_c[i] = '0; end
    for (int i = 0; i < PN; i++) begin stub_p[i] = '0; mod_p[i] = '0; end
    do_reset();
    step(PROT, 0, 0);
    // reserved bits set, pin field 01
    step(PROT, 1, 16'hFFF1);
    step(PROT, 0, 0);
    check("R2 reserved read zero", int'(bus_rdata), 1);
    step(CB, 1, 16'h1111);          // allowed
    step(CB + CN - 1, 1, 16'h2222); // last clk slot, allowed
    step(PB, 1, 16'h3333);          // pin protected, dropped
    step(PROT, 1, 16'h0004);        // clk on, pin off
    step(CB + 1, 1, 16'h4444);      // dropped
    step(PB + PN - 1, 1, 16'h5555); // allowed
    step(PB + PN, 1, 16'h6666);     // outside window
    step(PROT, 1, 16'h0000);
    check("R4 back to 00", int'(clk_protect), 0);
    step(PROT, 1, 16'h0005);
    step(PROT, 1, 16'h0000);
    step(8'h30, 1, 16'h000F);       // unrelated address
    check("R9 unrelated write no effect", int'(clk_protect | pin_protect), 0);
    step(PROT, 1, 16'h0009);        // clk 10 locked, pin 01
    check("R4 into locked", int'(clk_locked), 1);
    step(PROT, 1, 16'h0004);        // clk stays, pin -> 00
    check("R6 unlocked field updates", int'(pin_protect), 0);
    check("R6 locked field holds", int'(clk_protect), 0);
    step(PROT, 1, 16'h000F);        // clk stays, pin -> 11
    step(PROT, 1, 16'h0000);
    check("R5 both locked", int'(clk_locked & pin_locked), 1);
    step(CB + 2, 1, 16'h7777);      // clk off-locked: allowed
    step(PB + 3, 1, 16'h8888);      // pin on-locked: dropped
    step(PROT, 0, 0);
    do_reset();
    check("R10 lock cleared", int'(clk_locked | pin_locked), 0);
    step(PROT, 1, 16'h000C);
    step(CB, 1, 16'h9999);          // dropped
    step(PROT, 0, 0);
    @(negedge clk);
    for (int i = 0; i < CN; i++) check("R7 stub clk group", int'(stub_c[i]), int'(mod_c[i]));
    for (int i = 0; i < PN; i++) check("R8 stub pin group", int'(stub_p[i]), int'(mod_p[i]));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule